// File: doc/BRIEF.md
# FM Register Write Capture Encoder

This block sits beside the register write path of a two-bank FM synthesizer and turns the writes it sees into a compact stream of byte pairs. Each accepted write is looked up in a fixed map that folds the meaningful register addresses into 7-bit codes. The block keeps a shadow copy of every register so that writes that change nothing are left out. It measures the time between logged writes in millisecond ticks and emits that time as delay commands in front of the next register command. The consumer can replay the stream against the synthesizer.

Capture is armed by a level input and begins only at the first note-on style write. The block also works out which kind of chip setup the stream needs: a single chip, two independent chips, or the extended four-operator chip. Every command or delay takes exactly two output beats, a code byte and then a value byte. While those beats are pending, the write input is held off instead of losing data.

Top module: `fmcap_encoder`

## Requirements
- R1: Register codes are assigned consecutively from 0, in this order: low addresses 0x01, 0x04, 0x05, 0x08, 0xBD; then, for each offset i from 0 to 23 with (i & 7) < 6, the five addresses 0x20+i, 0x40+i, 0x60+i, 0x80+i, 0xE0+i; then, for each channel n from 0 to 8, the addresses 0xA0+n, 0xB0+n, 0xC0+n. This gives codes 0 to 121. A logged write emits the pair {code byte, value}. For example, 0x43 maps to 21, 0x35 to 90, 0xE0 to 9 and 0xC8 to 121.
- R2: During a capture, a write whose low 8 address bits are not in the map (for example 0x26, 0xA9) emits nothing.
- R3: During a capture, a write whose value equals the shadowed value of the same 9-bit address emits nothing.
- R4: For a write with address bit 8 set, bit 7 of the emitted code byte is set.
- R5: A gap of 1 to 256 ticks since the last logged write is emitted before the command as {122, gap-1}. A gap of 0 emits no delay.
- R6: A gap above 256 first emits {123, (gap>>8)-1}. If gap mod 256 is nonzero, {122, (gap mod 256)-1} follows.
- R7: If the gap before a loggable write exceeds 30000 ticks, the capture ends and that write emits nothing, unless it is itself a start trigger. A trigger starts a new capture with it.
- R8: While armed and not capturing, a write to low address 0xB0 to 0xB8 with value bit 5 set, or to 0xBD with value bits 5:0 above 0x20, starts a capture. That write is emitted as the first command with no delay before it, even if its value equals the shadow. Other writes emit nothing while no capture is running.
- R9: `hw_type_o` is cleared to 0 when a capture starts. A logged write of a nonzero value to 0x104 sets it to 2 if the shadowed 0x105 is nonzero. A logged nonzero write to 0x1B0 to 0x1B8 sets it to 1 while it is 0. It never takes the value 3.
- R10: The shadow is updated on every accepted write, whether or not a capture is running.
- R11: While output beats are pending, `wr_ready_o` is low. A byte that is valid and not taken stays valid and unchanged. No byte is dropped.
- R12: After reset, `out_valid_o` is 0, `wr_ready_o` is 1, `capturing_o` is 0 and `hw_type_o` is 0.
- R13: With `arm_i` low, an accepted write ends any capture and emits nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| arm_i | input | 1 | Capture enable level |
| tick_i | input | 1 | One-cycle pulse per millisecond |
| wr_valid_i | input | 1 | Register write offered |
| wr_ready_o | output | 1 | Register write accepted this cycle |
| wr_addr_i | input | ADDR_W | Register address, top bit selects the second bank |
| wr_data_i | input | 8 | Register value |
| out_valid_o | output | 1 | Stream byte valid |
| out_ready_i | input | 1 | Stream consumer ready |
| out_byte_o | output | 8 | Stream byte, code then value |
| capturing_o | output | 1 | A capture is running |
| hw_type_o | output | 2 | Detected setup: 0 single, 1 dual, 2 four-operator |

## Verification
The assertions check the output handshake on every cycle: a held byte stays stable, and the write input is stalled while bytes are pending. They also check that a capture never starts without its trigger command on the output, and that the setup type stays legal. Whether the right code, delay split, drop decision or capture end occurs depends on the write history and tick count. The bench's reference model shows these over directed scenarios, which include boundary gaps of 256, 257, 512, 30000 and 30001 ticks and a stalling consumer.

// File: rtl/fmcap_pkg.sv
package fmcap_pkg;
  localparam int BYTE_W = 8;
  localparam logic [BYTE_W-1:0] CODE_SHORT = 8'd122;
  localparam logic [BYTE_W-1:0] CODE_LONG  = 8'd123;
  localparam logic [1:0] HW_SINGLE = 2'd0;
  localparam logic [1:0] HW_DUAL   = 2'd1;
  localparam logic [1:0] HW_QUAD   = 2'd2;

  typedef enum logic [1:0] {ST_IDLE, ST_LOOK, ST_EMIT} enc_state_t;
endpackage

// File: rtl/fmcap_code_map.sv
module fmcap_code_map (
  input  logic [7:0] reg_lo,
  output logic       hit,
  output logic [6:0] code
);
  logic [4:0] off;
  logic [6:0] slot7, kind7, chan7;

  always_comb begin
    hit   = 1'b0;
    code  = 7'd0;
    off   = reg_lo[4:0];
    slot7 = {5'd0, off[4:3]} * 7'd6 + {4'd0, off[2:0]};
    chan7 = {3'd0, reg_lo[3:0]};
    kind7 = 7'd0;
    case (reg_lo)
      8'h01: begin hit = 1'b1; code = 7'd0; end
      8'h04: begin hit = 1'b1; code = 7'd1; end
      8'h05: begin hit = 1'b1; code = 7'd2; end
      8'h08: begin hit = 1'b1; code = 7'd3; end
      8'hBD: begin hit = 1'b1; code = 7'd4; end
      default: begin
        // operator group: 5 registers per operator slot
        if (off < 5'd24 && off[2:0] < 3'd6) begin
          case (reg_lo[7:5])
            3'd1: begin hit = 1'b1; kind7 = 7'd0; end
            3'd2: begin hit = 1'b1; kind7 = 7'd1; end
            3'd3: begin hit = 1'b1; kind7 = 7'd2; end
            3'd4: begin hit = 1'b1; kind7 = 7'd3; end
            3'd7: begin hit = 1'b1; kind7 = 7'd4; end
            default: hit = 1'b0;
          endcase
          code = 7'd5 + slot7 * 7'd5 + kind7;
        end
        // channel group: 3 registers per channel
        if (reg_lo[3:0] <= 4'd8) begin
          case (reg_lo[7:4])
            4'hA: begin hit = 1'b1; code = 7'd95 + chan7 * 7'd3; end
            4'hB: begin hit = 1'b1; code = 7'd96 + chan7 * 7'd3; end
            4'hC: begin hit = 1'b1; code = 7'd97 + chan7 * 7'd3; end
            default: ;
          endcase
        end
      end
    endcase
  end
endmodule

// File: rtl/fmcap_shadow_ram.sv
module fmcap_shadow_ram #(
  parameter int AW = 9,
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [DW-1:0] wdata,
  input  logic [AW-1:0] raddr,
  output logic [DW-1:0] rdata
);
  localparam int DEPTH = 1 << AW;
  logic [DW-1:0] mem [DEPTH];

  initial begin
    for (int i = 0; i < DEPTH; i++) mem[i] = '0;
  end

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
    rdata <= mem[raddr];
  end
endmodule

// File: rtl/fmcap_delay_split.sv
module fmcap_delay_split #(
  parameter int GAP_W = 15
) (
  input  logic [GAP_W-1:0] gap,
  output logic             long_en,
  output logic [7:0]       long_val,
  output logic             short_en,
  output logic [7:0]       short_val
);
  logic [GAP_W-1:0] hi_m1, all_m1;
  logic [7:0]       rem;

  always_comb begin
    hi_m1     = (gap >> 8) - GAP_W'(1);
    all_m1    = gap - GAP_W'(1);
    rem       = gap[7:0];
    long_en   = 1'b0;
    long_val  = 8'd0;
    short_en  = 1'b0;
    short_val = 8'd0;
    if (gap == '0) begin
      short_en = 1'b0;
    end else if (gap <= GAP_W'(256)) begin
      short_en  = 1'b1;
      short_val = all_m1[7:0];
    end else begin
      long_en   = 1'b1;
      long_val  = hi_m1[7:0];
      short_en  = (rem != 8'd0);
      short_val = rem - 8'd1;
    end
  end
endmodule

// File: rtl/fmcap_encoder.sv
module fmcap_encoder #(
  parameter int ADDR_W   = 9,
  parameter int LIMIT_MS = 30000
) (
  input  logic                          clk,
  input  logic                          rst,
  input  logic                          arm_i,
  input  logic                          tick_i,
  input  logic                          wr_valid_i,
  output logic                          wr_ready_o,
  input  logic [ADDR_W-1:0]             wr_addr_i,
  input  logic [fmcap_pkg::BYTE_W-1:0]  wr_data_i,
  output logic                          out_valid_o,
  input  logic                          out_ready_i,
  output logic [fmcap_pkg::BYTE_W-1:0]  out_byte_o,
  output logic                          capturing_o,
  output logic [1:0]                    hw_type_o
);
  import fmcap_pkg::*;

  localparam int GAP_W = $clog2(LIMIT_MS + 2);
  localparam logic [GAP_W-1:0] GAP_LIMIT = GAP_W'(LIMIT_MS);
  localparam logic [GAP_W-1:0] GAP_SAT   = GAP_W'(LIMIT_MS + 1);
  localparam logic [ADDR_W-1:0] A_QUAD_EN = ADDR_W'(9'h104);
  localparam logic [ADDR_W-1:0] A_NEWMODE = ADDR_W'(9'h105);
  localparam logic [ADDR_W-1:0] A_KEY2_LO = ADDR_W'(9'h1B0);
  localparam logic [ADDR_W-1:0] A_KEY2_HI = ADDR_W'(9'h1B8);

  enc_state_t        st_q;
  logic [ADDR_W-1:0] addr_q;
  logic [BYTE_W-1:0] data_q, old_val;
  logic [GAP_W-1:0]  gap_q;
  logic              cap_q, quad_q;
  logic [1:0]        hw_q;
  logic              long_en_q, short_en_q;
  logic [7:0]        long_val_q, short_val_q, cmd_q;
  logic [2:0]        slot_q, slot_nxt;
  logic [7:0]        out_byte_q;
  logic              out_valid_q;

  logic       look, map_hit;
  logic [6:0] map_code;
  logic       sp_long, sp_short;
  logic [7:0] sp_long_val, sp_short_val, cmd_byte;
  logic [7:0] lo;
  logic       is_trig, act, loggable, expired, log_now, trig_ok, emit, cap_d;
  logic       lng, sht;
  logic [1:0] hw_base, hw_d;
  logic [2:0] first_slot;

  function automatic logic [7:0] pick(input logic [2:0] s, input logic [7:0] lv,
                                      input logic [7:0] sv, input logic [7:0] cb,
                                      input logic [7:0] cv);
    case (s)
      3'd0:    pick = CODE_LONG;
      3'd1:    pick = lv;
      3'd2:    pick = CODE_SHORT;
      3'd3:    pick = sv;
      3'd4:    pick = cb;
      default: pick = cv;
    endcase
  endfunction

  assign look = (st_q == ST_LOOK);

  fmcap_shadow_ram #(.AW(ADDR_W), .DW(BYTE_W)) u_shadow (
    .clk(clk), .we(look), .waddr(addr_q), .wdata(data_q),
    .raddr(wr_addr_i), .rdata(old_val)
  );

  fmcap_code_map u_map (.reg_lo(addr_q[7:0]), .hit(map_hit), .code(map_code));

  fmcap_delay_split #(.GAP_W(GAP_W)) u_split (
    .gap(gap_q), .long_en(sp_long), .long_val(sp_long_val),
    .short_en(sp_short), .short_val(sp_short_val)
  );

  always_comb begin
    lo       = addr_q[7:0];
    cmd_byte = {addr_q[ADDR_W-1], map_code};
    is_trig  = ((lo >= 8'hB0) && (lo <= 8'hB8) && data_q[5]) ||
               ((lo == 8'hBD) && (data_q[5:0] > 6'h20));
    act      = cap_q && arm_i;
    loggable = act && map_hit && (old_val != data_q);
    expired  = gap_q > GAP_LIMIT;
    log_now  = loggable && !expired;
    trig_ok  = arm_i && is_trig && (!act || (loggable && expired));
    emit     = log_now || trig_ok;
    if (!arm_i)                    cap_d = 1'b0;
    else if (emit)                 cap_d = 1'b1;
    else if (loggable && expired)  cap_d = 1'b0;
    else                           cap_d = cap_q;
    hw_base = trig_ok ? HW_SINGLE : hw_q;
    hw_d    = hw_base;
    if (addr_q == A_QUAD_EN && data_q != '0 && quad_q)
      hw_d = HW_QUAD;
    else if (hw_base == HW_SINGLE && addr_q >= A_KEY2_LO && addr_q <= A_KEY2_HI && data_q != '0)
      hw_d = HW_DUAL;
    lng = log_now && sp_long;
    sht = log_now && sp_short;
    first_slot = lng ? 3'd0 : (sht ? 3'd2 : 3'd4);
    case (slot_q)
      3'd1:    slot_nxt = short_en_q ? 3'd2 : 3'd4;
      3'd3:    slot_nxt = 3'd4;
      default: slot_nxt = slot_q + 3'd1;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q        <= ST_IDLE;
      addr_q      <= '0;
      data_q      <= '0;
      gap_q       <= '0;
      cap_q       <= 1'b0;
      quad_q      <= 1'b0;
      hw_q        <= HW_SINGLE;
      long_en_q   <= 1'b0;
      short_en_q  <= 1'b0;
      long_val_q  <= '0;
      short_val_q <= '0;
      cmd_q       <= '0;
      slot_q      <= '0;
      out_byte_q  <= '0;
      out_valid_q <= 1'b0;
    end else begin
      if (look && emit)                    gap_q <= tick_i ? GAP_W'(1) : '0;
      else if (tick_i && gap_q < GAP_SAT)  gap_q <= gap_q + GAP_W'(1);
      case (st_q)
        ST_IDLE: if (wr_valid_i) begin
          addr_q <= wr_addr_i;
          data_q <= wr_data_i;
          st_q   <= ST_LOOK;
        end
        ST_LOOK: begin
          cap_q       <= cap_d;
          if (emit) hw_q <= hw_d;
          if (addr_q == A_NEWMODE) quad_q <= (data_q != '0);
          long_en_q   <= lng;
          short_en_q  <= sht;
          long_val_q  <= sp_long_val;
          short_val_q <= sp_short_val;
          cmd_q       <= cmd_byte;
          if (emit) begin
            slot_q      <= first_slot;
            out_byte_q  <= pick(first_slot, sp_long_val, sp_short_val, cmd_byte, data_q);
            out_valid_q <= 1'b1;
            st_q        <= ST_EMIT;
          end else begin
            st_q <= ST_IDLE;
          end
        end
        default: if (out_ready_i) begin
          if (slot_q == 3'd5) begin
            out_valid_q <= 1'b0;
            st_q        <= ST_IDLE;
          end else begin
            slot_q     <= slot_nxt;
            out_byte_q <= pick(slot_nxt, long_val_q, short_val_q, cmd_q, data_q);
          end
        end
      endcase
    end
  end

  assign wr_ready_o  = (st_q == ST_IDLE);
  assign out_valid_o = out_valid_q;
  assign out_byte_o  = out_byte_q;
  assign capturing_o = cap_q;
  assign hw_type_o   = hw_q;
endmodule

// File: rtl/fmcap_encoder_sva.sv
module fmcap_encoder_sva (
  input logic       clk,
  input logic       rst,
  input logic       wr_valid_i,
  input logic       wr_ready_o,
  input logic       out_valid_o,
  input logic       out_ready_i,
  input logic [7:0] out_byte_o,
  input logic       capturing_o,
  input logic [1:0] hw_type_o
);
  logic [6:0] c7;
  logic       trig_code;

  always_comb begin
    c7        = out_byte_o[6:0];
    trig_code = (c7 == 7'd4) ||
                ((c7 >= 7'd96) && (c7 <= 7'd120) && (((c7 - 7'd96) % 7'd3) == 7'd0));
  end

  assert_hold_R11: assert property (@(posedge clk) disable iff (rst)
    (out_valid_o && !out_ready_i) |=> (out_valid_o && $stable(out_byte_o)));

  assert_busy_R11: assert property (@(posedge clk) disable iff (rst)
    out_valid_o |-> !wr_ready_o);

  assert_accept_R11: assert property (@(posedge clk) disable iff (rst)
    (wr_valid_i && wr_ready_o) |=> !wr_ready_o);

  assert_trigger_first_R8: assert property (@(posedge clk) disable iff (rst)
    $rose(capturing_o) |-> (out_valid_o && trig_code));

  assert_hw_legal_R9: assert property (@(posedge clk) disable iff (rst)
    hw_type_o != 2'd3);

  assert_reset_R12: assert property (@(posedge clk)
    $past(rst) |-> (!out_valid_o && wr_ready_o && !capturing_o && hw_type_o == 2'd0));
endmodule

bind fmcap_encoder fmcap_encoder_sva u_sva (
  .clk(clk), .rst(rst), .wr_valid_i(wr_valid_i), .wr_ready_o(wr_ready_o),
  .out_valid_o(out_valid_o), .out_ready_i(out_ready_i), .out_byte_o(out_byte_o),
  .capturing_o(capturing_o), .hw_type_o(hw_type_o)
);

// File: tb/fmcap_encoder_tb_top.sv
module fmcap_encoder_tb_top;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       arm = 1'b0;
  logic       tick = 1'b0;
  logic       wr_valid = 1'b0;
  logic       wr_ready;
  logic [8:0] wr_addr = '0;
  logic [7:0] wr_data = '0;
  logic       out_valid;
  logic       out_ready = 1'b0;
  logic [7:0] out_byte;
  logic       capturing;
  logic [1:0] hw_type;

  fmcap_encoder dut_i (
    .clk(clk), .rst(rst), .arm_i(arm), .tick_i(tick),
    .wr_valid_i(wr_valid), .wr_ready_o(wr_ready), .wr_addr_i(wr_addr), .wr_data_i(wr_data),
    .out_valid_o(out_valid), .out_ready_i(out_ready), .out_byte_o(out_byte),
    .capturing_o(capturing), .hw_type_o(hw_type)
  );

  always #4 clk = ~clk;

  int    n_checks = 0;
  int    n_fail = 0;
  string cur_req = "R12";
  int    ref_map [256];
  int    shadow [512];
  bit    cap_m = 0;
  bit    quad_m = 0;
  int    hw_m = 0;
  int    gap_m = 0;
  int    expq [$];
  bit    stall_on = 0;
  int    cyc = 0;
  bit    prev_hold = 0;
  logic [7:0] prev_byte = '0;

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  endtask

  // consumer and byte comparison, away from the active edge
  always @(negedge clk) begin
    bit rdy;
    cyc++;
    if (!rst) begin
      if (prev_hold)
        check(out_valid && out_byte == prev_byte, "R11", "held byte", out_byte, prev_byte);
      if (out_valid && wr_ready)
        check(0, "R11", "write ready while bytes pending", 1, 0);
      rdy = !stall_on || (cyc % 3 == 2);
      out_ready = rdy;
      if (out_valid && rdy) begin
        if (expq.size() == 0) check(0, cur_req, "unexpected byte", out_byte, -1);
        else begin
          int e;
          e = expq.pop_front();
          check(out_byte == 8'(e), cur_req, "stream byte (R1)", out_byte, e);
        end
      end
      prev_hold = out_valid && !rdy;
      prev_byte = out_byte;
    end
  end

  always @(posedge clk) begin
    if (cyc > 190000) begin
      check(0, "WD", "watchdog expired", cyc, 190000);
      finish_run();
    end
  end

  function automatic bit is_trig(input int lo, input int d);
    return (lo >= 'hB0 && lo <= 'hB8 && (d & 'h20) != 0) || (lo == 'hBD && (d & 'h3F) > 'h20);
  endfunction

  task automatic log_cmd(input int a, input int d);
    if (a == 'h104 && d != 0 && quad_m) hw_m = 2;
    else if (hw_m == 0 && a >= 'h1B0 && a <= 'h1B8 && d != 0) hw_m = 1;
    expq.push_back(ref_map[a & 255] | ((a >= 256) ? 128 : 0));
    expq.push_back(d);
    gap_m = 0;
  endtask

  task automatic model_accept(input int a, input int d);
    bit act, start, mapped;
    int g;
    mapped = ref_map[a & 255] != 255;
    act = cap_m && arm;
    start = 0;
    if (!arm) cap_m = 0;
    if (act) begin
      if (mapped && shadow[a] != d) begin
        if (gap_m > 30000) begin
          cap_m = 0;
          start = is_trig(a & 255, d);
        end else begin
          g = gap_m;
          while (g > 0) begin
            if (g < 257) begin expq.push_back(122); expq.push_back(g - 1); g = 0; end
            else begin
              int s;
              s = g >> 8;
              expq.push_back(123); expq.push_back(s - 1);
              g = g - (s << 8);
            end
          end
          log_cmd(a, d);
        end
      end
    end else if (arm) start = is_trig(a & 255, d);
    if (start) begin
      cap_m = 1;
      hw_m = 0;
      log_cmd(a, d);
    end
    if (a == 'h105) quad_m = (d != 0);
    shadow[a] = d;
  endtask

  task automatic wr(input int a, input int d);
    while (!wr_ready) @(negedge clk);
    wr_valid = 1'b1;
    wr_addr  = 9'(a);
    wr_data  = 8'(d);
    model_accept(a, d);
    @(negedge clk);
    wr_valid = 1'b0;
    while (!(wr_ready && !out_valid)) @(negedge clk);
    check(expq.size() == 0, cur_req, "bytes missing", expq.size(), 0);
    check(capturing == cap_m, cur_req, "capturing", capturing, cap_m);
    check(hw_type == 2'(hw_m), "R9", "hw type", hw_type, hw_m);
  endtask

  task automatic ticks(input int n);
    tick = 1'b1;
    repeat (n) @(negedge clk);
    tick = 1'b0;
    gap_m = gap_m + n;
    if (gap_m > 30001) gap_m = 30001;
  endtask

  initial begin
    int idx;
    for (int i = 0; i < 256; i++) ref_map[i] = 255;
    for (int i = 0; i < 512; i++) shadow[i] = 0;
    idx = 0;
    ref_map['h01] = idx++; ref_map['h04] = idx++; ref_map['h05] = idx++;
    ref_map['h08] = idx++; ref_map['hBD] = idx++;
    for (int i = 0; i < 24; i++) begin
      if ((i & 7) < 6) begin
        ref_map['h20 + i] = idx++; ref_map['h40 + i] = idx++; ref_map['h60 + i] = idx++;
        ref_map['h80 + i] = idx++; ref_map['hE0 + i] = idx++;
      end
    end
    for (int n = 0; n < 9; n++) begin
      ref_map['hA0 + n] = idx++; ref_map['hB0 + n] = idx++; ref_map['hC0 + n] = idx++;
    end

    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    cur_req = "R12";
    check(!out_valid, "R12", "out_valid after reset", out_valid, 0);
    check(wr_ready, "R12", "wr_ready after reset", wr_ready, 1);
    check(!capturing, "R12", "capturing after reset", capturing, 0);
    check(hw_type == 2'd0, "R12", "hw type after reset", hw_type, 0);

    cur_req = "R13"; arm = 1'b0;
    wr('hB0, 'h20);
    cur_req = "R8"; arm = 1'b1;
    wr('h40, 'h3F);
    wr('hBD, 'h20);
    ticks(7);
    wr('hB0, 'h20);
    cur_req = "R5"; stall_on = 1;
    ticks(5);  wr('h43, 'h11);
    cur_req = "R3";  wr('h43, 'h11);
    cur_req = "R10"; wr('h40, 'h3F);
    cur_req = "R2";  wr('h26, 'h01); wr('hA9, 'h01);
    cur_req = "R5";  ticks(256); wr('hE0, 'h07);
    cur_req = "R6";  ticks(257); wr('h1A0, 'h55);
    cur_req = "R4";  wr('h1C8, 'h03);
    cur_req = "R6";  ticks(512); wr('hC8, 'h03);
    ticks(30000); wr('h35, 'h09);
    cur_req = "R1"; stall_on = 0;
    wr('h01, 'h20); wr('h04, 'h01); wr('h05, 'h01); wr('h08, 'h40);
    wr('hBD, 'h3F); wr('hF5, 'h02); wr('hA0, 'h81); wr('hB8, 'h11);
    cur_req = "R9"; stall_on = 1;
    wr('h104, 'h01); wr('h105, 'h01); wr('h104, 'h02); wr('h1B0, 'h21);
    cur_req = "R7";
    ticks(30001); wr('h20, 'h05);
    wr('h21, 'h05);
    ticks(30001); wr('h1B3, 'h20);
    cur_req = "R13"; arm = 1'b0;
    wr('h60, 'h01);
    wr('hB1, 'h20);
    repeat (4) @(negedge clk);
    check(expq.size() == 0, "R11", "no bytes lost at end", expq.size(), 0);
    finish_run();
  end
endmodule